// File: doc/BRIEF.md
# Multiplexed Byte-Wide Register Bus Slave

This block connects a bank of 16-bit internal registers to an external 8-bit bus on which address and data share the same lines. The external side has four controls: an active-low chip select, an active-low byte strobe, a direction line and an address-latch pulse. None of them is related to the system clock. The block samples all of them through synchronizers and then works only on the synchronized copies and the edges found in them.

A host first opens an access with an address-latch pulse that carries the register address on the shared lines. After that it moves whole words as pairs of byte strobes, high byte first. The level of the direction line decides whether each strobe writes or reads. After each complete word the internal address moves to the next register, so a burst needs only one address phase.

On writes, the high byte is held aside and the register is written only once the low byte arrives. On reads, the whole word is captured when the high byte is requested, so the two halves always come from the same value. The block enables its output drivers only while a read strobe is active. The register bank is reached through a plain address, write-data, write-enable and combinational read-data port.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `bus_ad_oe` and `reg_we` are 0, `reg_addr` is 0 and the next byte of a word is the high byte.
- R2: A rising edge of `bus_ale` while `bus_cs_n` is low loads `reg_addr` with the byte on `bus_ad_in`, and the next byte becomes a high byte.
- R3: With `bus_wr_n` low, each rising edge of `bus_rd_n` samples `bus_ad_in`. The first byte of a word is staged and causes no write. The second byte causes exactly one cycle of `reg_we`, with `reg_wdata` = {first byte, second byte} (first byte in bits 15:8) and `reg_addr` at the word's address.
- R4: `reg_addr` increments by one after each complete word, for reads and writes alike, and wraps from 255 to 0.
- R5: With `bus_wr_n` high, by the third clock edge after `bus_rd_n` falls, `bus_ad_oe` is 1 and `bus_ad_out` holds the byte. The high byte is bits 15:8 of `reg_rdata` sampled at that strobe. The low byte is bits 7:0 of that same sample, even if the register changes in between.
- R6: `bus_ad_oe` returns to 0 by the third clock edge after `bus_rd_n` rises, and it is never 1 during a write strobe.
- R7: While `bus_cs_n` is high, strobes and address-latch pulses are ignored: no write, no output enable and no address change. The next byte after `bus_cs_n` falls again is a high byte.
- R8: Strobe and address-latch pulses that are two system clock periods wide, low and high, are accepted.
- R9: A strobe rising edge whose synchronized sample falls in the same cycle as chip select going high is discarded: no write occurs and the next word starts with a high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Byte strobe, active low |
| bus_wr_n | input | 1 | Direction: low = write, high = read |
| bus_ale | input | 1 | Address-latch pulse, active high |
| bus_ad_in | input | 8 | Shared address/data lines, input side |
| bus_ad_out | output | 8 | Shared lines, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| reg_addr | output | 8 | Register bank address |
| reg_wdata | output | 16 | Register bank write data |
| reg_we | output | 1 | Register bank write enable, one cycle per word |
| reg_rdata | input | 16 | Register bank read data for `reg_addr` |

## Verification
The end of a word can land in the same synchronized sample as chip select going high. When this happens, the low-byte commit and the deselect reset of the byte pointer compete in one cycle. The bench provokes this by raising the strobe and chip select in the same time step, after a staged high byte. It then judges the outcome at the register port: the write-pulse count must not change and the register must keep its value. A fresh word written after reselect must land whole, which shows that the pointer went back to the high byte.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } byte_phase_e;
endpackage

// File: rtl/mbs_rst_sync.sv
module mbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain[STAGES-1];
endmodule

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int              W       = 12,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          rd_n_s,
  input  logic          wr_n_s,
  input  logic          ale_s,
  input  logic [BW-1:0] ad_s,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic [BW-1:0] ad_out,
  output logic          ad_oe
);
  logic          rd_n_q, ale_q;
  byte_phase_e   phase, phase_nx;
  logic [AW-1:0] addr, addr_nx;
  logic [BW-1:0] stage, stage_nx;
  logic [DW-1:0] snap, snap_nx;
  logic [BW-1:0] out, out_nx;
  logic          oe, oe_nx;
  logic          we, we_nx;
  logic [DW-1:0] wdata, wdata_nx;

  logic cs_act, rd_fall, rd_rise, ale_rise, is_read;

  always_comb begin
    cs_act   = !cs_n_s;
    is_read  = wr_n_s;
    rd_fall  = cs_act &&  rd_n_q && !rd_n_s;
    rd_rise  = cs_act && !rd_n_q &&  rd_n_s;
    ale_rise = cs_act &&  ale_s  && !ale_q;
  end

  always_comb begin
    phase_nx = phase;
    addr_nx  = addr;
    stage_nx = stage;
    snap_nx  = snap;
    out_nx   = out;
    oe_nx    = oe;
    we_nx    = 1'b0;
    wdata_nx = wdata;

    if (we) addr_nx = addr + 1'b1;

    if (!cs_act) begin
      phase_nx = PH_HI;
      oe_nx    = 1'b0;
    end else begin
      if (ale_rise) begin
        addr_nx  = AW'(ad_s);
        phase_nx = PH_HI;
      end
      if (rd_fall && is_read) begin
        oe_nx = 1'b1;
        if (phase == PH_HI) begin
          snap_nx = reg_rdata;
          out_nx  = reg_rdata[DW-1:BW];
        end else begin
          out_nx  = snap[BW-1:0];
        end
      end
      if (rd_rise) begin
        oe_nx = 1'b0;
        if (phase == PH_HI) begin
          phase_nx = PH_LO;
          if (!is_read) stage_nx = ad_s;
        end else begin
          phase_nx = PH_HI;
          if (is_read) begin
            addr_nx = addr + 1'b1;
          end else begin
            we_nx    = 1'b1;
            wdata_nx = {stage, ad_s};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n_q <= 1'b1;
      ale_q  <= 1'b0;
      phase  <= PH_HI;
      addr   <= '0;
      stage  <= '0;
      snap   <= '0;
      out    <= '0;
      oe     <= 1'b0;
      we     <= 1'b0;
      wdata  <= '0;
    end else begin
      rd_n_q <= rd_n_s;
      ale_q  <= ale_s;
      phase  <= phase_nx;
      addr   <= addr_nx;
      stage  <= stage_nx;
      snap   <= snap_nx;
      out    <= out_nx;
      oe     <= oe_nx;
      we     <= we_nx;
      wdata  <= wdata_nx;
    end
  end

  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign reg_we    = we;
  assign ad_out    = out;
  assign ad_oe     = oe;
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int AW          = 8,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = 2 * BW,
  localparam int SW = BW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_ale,
  input  logic [BW-1:0] bus_ad_in,
  output logic [BW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic          rst_sn;
  logic [SW-1:0] raw, synced;
  logic          cs_n_s, rd_n_s, wr_n_s, ale_s;
  logic [BW-1:0] ad_s;

  mbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  assign raw = {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_ad_in};

  mbs_sync #(
    .W(SW), .STAGES(SYNC_STAGES),
    .RST_VAL({4'b1110, {BW{1'b0}}})
  ) u_sync (
    .clk(clk), .rst_n(rst_sn), .d(raw), .q(synced)
  );

  assign {cs_n_s, rd_n_s, wr_n_s, ale_s, ad_s} = synced;

  mbs_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .cs_n_s(cs_n_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
    .ale_s(ale_s), .ad_s(ad_s), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          cs_n_s,
  input logic          wr_n_s,
  input logic          bus_ad_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr
);
  // R3: a word commits as one single-cycle pulse
  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_we |=> !reg_we);

  // R6: the output is never enabled while a write is being committed
  p_no_oe_on_write_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    reg_we |-> !bus_ad_oe);

  // R4: the address steps by one right after a committed write
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(reg_we) |-> reg_addr == $past(reg_addr) + 1'b1);

  // R7: deselect clears the enable and blocks writes
  p_cs_idle_oe_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n_s |=> !bus_ad_oe);

  p_cs_idle_we_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n_s |=> !reg_we);

  // R5: the output turns on only for a read-direction strobe
  p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(bus_ad_oe) |-> $past(wr_n_s));
endmodule

bind mux_bus_slave mbs_checker #(.AW(AW)) u_mbs_checker (
  .clk(clk), .rst_sn(rst_sn), .cs_n_s(cs_n_s), .wr_n_s(wr_n_s),
  .bus_ad_oe(bus_ad_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/mux_bus_slave_bench.sv
module mux_bus_slave_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale = 1'b0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;

  logic [15:0] mem [256];
  int vectors = 0, errors = 0, we_count = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mux_bus_slave u_mux_bus_slave (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .bus_ale(ale), .bus_ad_in(ad_in),
    .bus_ad_out(ad_out), .bus_ad_oe(ad_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_cs(input logic v);
    cs_n = v; tick(3);
  endtask

  task automatic addr_phase(input logic [7:0] a, input int w);
    ad_in = a; tick(1);
    ale = 1'b1; tick(w);
    ale = 1'b0; tick(w);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int w);
    wr_n = 1'b0; ad_in = b; tick(1);
    rd_n = 1'b0; tick(w);
    chk("R6 oe during write", ad_oe, 0);
    rd_n = 1'b1; tick(w);
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string req);
    wr_n = 1'b1; tick(1);
    rd_n = 1'b0; tick(3);
    chk({req, " oe"}, ad_oe, 1);
    chk({req, " data"}, ad_out, exp);
    tick(1);
    rd_n = 1'b1; tick(3);
    chk("R6 oe release", ad_oe, 0);
    tick(1);
  endtask

  task automatic t_reset;
    chk("R1 oe", ad_oe, 0);
    chk("R1 we", reg_we, 0);
    chk("R1 addr", reg_addr, 0);
  endtask

  task automatic t_write_pair;
    int base;
    set_cs(1'b0);
    addr_phase(8'h10, 4);
    chk("R2 addr", reg_addr, 8'h10);
    base = we_count;
    wr_byte(8'hAB, 4);
    chk("R3 no write on high byte", we_count, base);
    wr_byte(8'hCD, 4);
    chk("R3 word", mem[8'h10], 16'hABCD);
    chk("R3 one pulse", we_count, base + 1);
    chk("R4 addr step", reg_addr, 8'h11);
    wr_byte(8'h12, 4);
    wr_byte(8'h34, 4);
    chk("R4 burst word", mem[8'h11], 16'h1234);
    set_cs(1'b1);
  endtask

  task automatic t_read_pair;
    mem[8'h20] = 16'hBEEF;
    mem[8'h21] = 16'h0102;
    set_cs(1'b0);
    addr_phase(8'h20, 4);
    rd_byte(8'hBE, "R5 high");
    rd_byte(8'hEF, "R5 low");
    rd_byte(8'h01, "R4 next high");
    rd_byte(8'h02, "R4 next low");
    chk("R4 read addr", reg_addr, 8'h22);
    set_cs(1'b1);
  endtask

  task automatic t_snapshot;
    mem[8'h30] = 16'h5566;
    set_cs(1'b0);
    addr_phase(8'h30, 4);
    rd_byte(8'h55, "R5 snap high");
    mem[8'h30] = 16'h7788;
    rd_byte(8'h66, "R5 snap low");
    set_cs(1'b1);
  endtask

  task automatic t_cs_abort;
    int base;
    set_cs(1'b0);
    addr_phase(8'h40, 4);
    wr_byte(8'h99, 4);
    set_cs(1'b1);
    base = we_count;
    wr_n = 1'b1; rd_n = 1'b0; tick(4);
    chk("R7 oe while deselected", ad_oe, 0);
    rd_n = 1'b1; tick(2);
    addr_phase(8'h77, 4);
    chk("R7 addr kept", reg_addr, 8'h40);
    wr_byte(8'h01, 4);
    wr_byte(8'h02, 4);
    chk("R7 no write while deselected", we_count, base);
    set_cs(1'b0);
    wr_byte(8'h11, 4);
    wr_byte(8'h22, 4);
    chk("R7 restart at high byte", mem[8'h40], 16'h1122);
    set_cs(1'b1);
  endtask

  task automatic t_wrap;
    set_cs(1'b0);
    addr_phase(8'hFF, 4);
    wr_byte(8'hC0, 4);
    wr_byte(8'hDE, 4);
    chk("R4 last word", mem[8'hFF], 16'hC0DE);
    chk("R4 wrap", reg_addr, 8'h00);
    set_cs(1'b1);
  endtask

  task automatic t_coincide;
    int base;
    mem[8'h50] = 16'h0000;
    set_cs(1'b0);
    addr_phase(8'h50, 4);
    wr_byte(8'h33, 4);
    base = we_count;
    wr_n = 1'b0; ad_in = 8'h44; tick(1);
    rd_n = 1'b0; tick(4);
    rd_n = 1'b1; cs_n = 1'b1; tick(4);
    chk("R9 no write", we_count, base);
    chk("R9 reg kept", mem[8'h50], 16'h0000);
    set_cs(1'b0);
    wr_byte(8'h5A, 4);
    wr_byte(8'hA5, 4);
    chk("R9 fresh word", mem[8'h50], 16'h5AA5);
    set_cs(1'b1);
  endtask

  task automatic t_min_pulse;
    set_cs(1'b0);
    addr_phase(8'h60, 2);
    tick(2);
    chk("R8 addr", reg_addr, 8'h60);
    wr_byte(8'h9A, 2);
    wr_byte(8'hBC, 2);
    wr_byte(8'hDE, 2);
    wr_byte(8'hF0, 2);
    tick(4);
    chk("R8 word 0", mem[8'h60], 16'h9ABC);
    chk("R8 word 1", mem[8'h61], 16'hDEF0);
    set_cs(1'b1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write_pair();
    t_read_pair();
    t_snapshot();
    t_cs_abort();
    t_wrap();
    t_coincide();
    t_min_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule